// File: doc/BRIEF.md
# I2C High-Speed Mode Entry Detector

This block sits on the target side of an I2C bus, after the analog glitch filters. It oversamples SCL and SDA with a system clock and passes both lines through two-flop synchronizers. It detects start and stop conditions. A repeated start is simply a start seen while the bus is busy.

After every start, the block captures the first byte. If the bus is in standard/fast mode and that byte has the form 00001xxx, the byte is the high-speed master code. The block then raises a sticky high-speed mode output, which selects the faster input filter setting. During the ninth clock of that byte it also raises an acknowledge-suppress output, so that the byte-level target logic leaves SDA released.

High-speed mode stays set through any number of repeated starts. Only a stop condition clears it. The system clock must run at least eight times the highest SCL rate, so that the short high phase of SCL in high-speed operation is seen reliably.

Top module: `hs_entry_det`

## Requirements
- R1: While rst_ni is low and right after it is released with both lines idle high, hs_mode_o, ack_suppress_o, start_o and stop_o are all 0.
- R2: SDA going low while SCL stays high gives exactly one single-cycle pulse on start_o. This holds for both first and repeated starts.
- R3: SDA going high while SCL stays high gives exactly one single-cycle pulse on stop_o.
- R4: In standard/fast mode, a first byte after a start whose upper five bits are 00001 sets hs_mode_o to 1, for every value of the three low bits. Bits arrive MSB first and are sampled on SCL rising.
- R5: For a recognized master code, ack_suppress_o is 1 during the high phase of the ninth SCL clock and returns to 0 once SCL falls at the end of that clock. After any byte that is not a recognized master code, it stays 0.
- R6: A first byte whose upper five bits differ from 00001 leaves hs_mode_o at 0 and ack_suppress_o at 0.
- R7: Once set, hs_mode_o stays 1 across repeated starts and the bytes that follow them.
- R8: A stop condition returns hs_mode_o and ack_suppress_o to 0.
- R9: In high-speed mode, a first byte of the form 00001xxx is ordinary traffic: ack_suppress_o stays 0 and hs_mode_o stays 1.
- R10: Only the first byte after a start is compared. A later byte of the form 00001xxx in the same transfer changes nothing.
- R11: If the synchronized SCL rise and SDA fall appear in the same sample, the event counts as a data edge and not as a start: start_o stays 0.
- R12: SDA changes while SCL is low produce no start or stop pulse, and they do not disturb the next byte's capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 8x the SCL rate |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Filtered SCL line, asynchronous |
| sda_i | input | 1 | Filtered SDA line, asynchronous |
| hs_mode_o | output | 1 | 1 selects high-speed filtering, 0 selects standard/fast |
| ack_suppress_o | output | 1 | 1 tells the target logic not to drive an acknowledge |
| start_o | output | 1 | Single-cycle pulse on a start or repeated start |
| stop_o | output | 1 | Single-cycle pulse on a stop |

## Verification
The sampling edge and the start detector can fire in the same synchronized sample when SCL rises and SDA falls together. The bench provokes this by changing both lines on the same clock. It judges the result by the start pulse count staying unchanged and the mode output staying 0. A second overlap concerns the end of the ninth clock and a repeated start, which both clear the acknowledge-suppress output. The bench issues repeated starts right after master-code bytes, and random transfers mix first bytes, second bytes, repeated starts and stops. A bench-side model of the sticky mode judges each of these transfers.

// File: rtl/hsd_pkg.sv
package hsd_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_DATA   = 2'd1,
    PH_ACK_LO = 2'd2,
    PH_ACK_HI = 2'd3
  } phase_e;

  typedef struct packed {
    logic scl_rise;
    logic scl_fall;
    logic start;
    logic stop;
  } bus_ev_t;
endpackage

// File: rtl/hsd_sync.sv
module hsd_sync #(
  parameter int unsigned STAGES    = 2,
  parameter bit          RESET_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= {STAGES{RESET_VAL}};
    else if (STAGES == 1) ff_q <= d_i;
    else ff_q <= {ff_q[STAGES-2:0], d_i};
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/hsd_cond_det.sv
module hsd_cond_det
  import hsd_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    scl_s_i,
  input  logic    sda_s_i,
  output bus_ev_t ev_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s_i;
      sda_q <= sda_s_i;
    end
  end

  // SCL must be high in both samples; a simultaneous SCL rise is a data edge
  assign ev_o.scl_rise = !scl_q && scl_s_i;
  assign ev_o.scl_fall = scl_q && !scl_s_i;
  assign ev_o.start    = scl_q && scl_s_i && sda_q && !sda_s_i;
  assign ev_o.stop     = scl_q && scl_s_i && !sda_q && sda_s_i;

  a_r2_start_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_o.start |=> !ev_o.start);
  a_r3_stop_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_o.stop |=> !ev_o.stop);
  a_r11_rise_not_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_o.scl_rise |-> !ev_o.start);
endmodule

// File: rtl/hsd_byte_cap.sv
module hsd_byte_cap
  import hsd_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned CNT_W = $clog2(BYTE_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  bus_ev_t           ev_i,
  input  logic              sda_s_i,
  output logic              byte_done_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              ack_end_o
);
  phase_e            phase_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] shreg_q;
  logic              last_bit;

  assign last_bit    = (cnt_q == CNT_W'(BYTE_W - 1));
  assign byte_done_o = (phase_q == PH_DATA) && ev_i.scl_rise && last_bit;
  assign byte_o      = {shreg_q[BYTE_W-2:0], sda_s_i};
  assign ack_end_o   = (phase_q == PH_ACK_HI) && ev_i.scl_fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      shreg_q <= '0;
    end else if (ev_i.start) begin
      phase_q <= PH_DATA;
      cnt_q   <= '0;
      shreg_q <= '0;
    end else if (ev_i.stop) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (phase_q)
        PH_DATA: if (ev_i.scl_rise) begin
          shreg_q <= byte_o;
          if (last_bit) begin
            phase_q <= PH_ACK_LO;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_ACK_LO: if (ev_i.scl_rise) phase_q <= PH_ACK_HI;
        PH_ACK_HI: if (ev_i.scl_fall) phase_q <= PH_IDLE;
        default: ;
      endcase
    end
  end

  a_r10_cnt_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(BYTE_W - 1));
  a_r10_one_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_done_o |=> (phase_q == PH_ACK_LO));
endmodule

// File: rtl/hsd_mode_ctl.sv
module hsd_mode_ctl #(
  parameter int unsigned       BYTE_W   = 8,
  parameter logic [BYTE_W-1:0] MC_VALUE = 8'b0000_1000,
  parameter logic [BYTE_W-1:0] MC_MASK  = 8'b1111_1000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              byte_done_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              ack_end_i,
  output logic              hs_mode_o,
  output logic              ack_suppress_o
);
  logic hs_q, ack_q, mc_hit;

  // compare only while still in standard/fast mode
  assign mc_hit = byte_done_i && !hs_q && ((byte_i & MC_MASK) == (MC_VALUE & MC_MASK));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hs_q  <= 1'b0;
      ack_q <= 1'b0;
    end else if (stop_i) begin
      hs_q  <= 1'b0;
      ack_q <= 1'b0;
    end else if (mc_hit) begin
      hs_q  <= 1'b1;
      ack_q <= 1'b1;
    end else if (start_i || ack_end_i) begin
      ack_q <= 1'b0;
    end
  end

  assign hs_mode_o      = hs_q;
  assign ack_suppress_o = ack_q;

  a_r8_stop_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (!hs_q && !ack_q));
  a_r7_hs_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hs_q && !stop_i) |=> hs_q);
  a_r4_set_by_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hs_q) |-> $past(byte_done_i));
  a_r5_ack_in_hs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_q |-> hs_q);
  a_r9_no_ack_in_hs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hs_q && byte_done_i) |=> !ack_q);
endmodule

// File: rtl/hs_entry_det.sv
module hs_entry_det
  import hsd_pkg::*;
#(
  parameter int unsigned       SYNC_STAGES = 2,
  parameter int unsigned       BYTE_W      = 8,
  parameter logic [BYTE_W-1:0] MC_VALUE    = 8'b0000_1000,
  parameter logic [BYTE_W-1:0] MC_MASK     = 8'b1111_1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic hs_mode_o,
  output logic ack_suppress_o,
  output logic start_o,
  output logic stop_o
);
  localparam int unsigned N_LINES = 2;

  logic [N_LINES-1:0] line_raw, line_s;
  bus_ev_t            ev;
  logic               byte_done, ack_end;
  logic [BYTE_W-1:0]  byte_val;

  assign line_raw = {scl_i, sda_i};

  for (genvar g = 0; g < N_LINES; g++) begin : g_sync
    hsd_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (line_raw[g]),
      .q_o   (line_s[g])
    );
  end

  hsd_cond_det u_cond (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .scl_s_i(line_s[1]),
    .sda_s_i(line_s[0]),
    .ev_o   (ev)
  );

  hsd_byte_cap #(.BYTE_W(BYTE_W)) u_cap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ev_i       (ev),
    .sda_s_i    (line_s[0]),
    .byte_done_o(byte_done),
    .byte_o     (byte_val),
    .ack_end_o  (ack_end)
  );

  hsd_mode_ctl #(.BYTE_W(BYTE_W), .MC_VALUE(MC_VALUE), .MC_MASK(MC_MASK)) u_mode (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .start_i       (ev.start),
    .stop_i        (ev.stop),
    .byte_done_i   (byte_done),
    .byte_i        (byte_val),
    .ack_end_i     (ack_end),
    .hs_mode_o     (hs_mode_o),
    .ack_suppress_o(ack_suppress_o)
  );

  assign start_o = ev.start;
  assign stop_o  = ev.stop;

  a_r1_reset_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (!hs_mode_o && !ack_suppress_o));
  a_r12_no_cond_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!line_s[1]) |-> (!start_o && !stop_o));
endmodule

// File: tb/hs_entry_det_tb_top.sv
module hs_entry_det_tb_top;
  localparam int Q = 6;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic scl = 1'b1, sda = 1'b1;
  logic hs_mode, ack_sup, start_p, stop_p;
  int   checks = 0, errors = 0;
  int   start_cnt = 0, stop_cnt = 0, exp_start = 0, exp_stop = 0;
  bit   exp_hs = 1'b0;
  bit   done = 1'b0;

  always #2 clk_i = ~clk_i;

  hs_entry_det dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl), .sda_i(sda),
    .hs_mode_o(hs_mode), .ack_suppress_o(ack_sup),
    .start_o(start_p), .stop_o(stop_p)
  );

  always @(negedge clk_i) begin
    if (rst_ni && start_p) start_cnt++;
    if (rst_ni && stop_p)  stop_cnt++;
  end

  function automatic bit is_mc(input logic [7:0] b, input bit hs);
    return !hs && (b[7:3] == 5'b00001);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk_i);
  endtask

  task automatic bus_start();
    sda = 1'b1; wq();
    scl = 1'b1; wq();
    sda = 1'b0; wq();
    scl = 1'b0; wq();
    exp_start++;
    chk(start_cnt == exp_start, "R2 start count", start_cnt, exp_start);
    chk(ack_sup == 1'b0, "R5 ack cleared by start", ack_sup, 0);
  endtask

  task automatic bus_stop();
    sda = 1'b0; wq();
    scl = 1'b1; wq();
    sda = 1'b1; wq();
    exp_stop++;
    exp_hs = 1'b0;
    chk(stop_cnt == exp_stop, "R3 stop count", stop_cnt, exp_stop);
    chk(hs_mode == 1'b0, "R8 stop clears mode", hs_mode, 0);
  endtask

  task automatic send_byte(input logic [7:0] v, input bit exp_ack, input string req);
    for (int i = 7; i >= 0; i--) begin
      sda = v[i]; wq();
      scl = 1'b1; wq();
      scl = 1'b0; wq();
    end
    sda = 1'b1; wq();
    scl = 1'b1; wq();
    chk(ack_sup == exp_ack, req, ack_sup, exp_ack);
    if (exp_ack) exp_hs = 1'b1;
    chk(hs_mode == exp_hs, req, hs_mode, exp_hs);
    scl = 1'b0; wq();
    chk(ack_sup == 1'b0, "R5 ack released after ninth clock", ack_sup, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] b;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk_i);
    chk(hs_mode == 0 && ack_sup == 0 && start_p == 0 && stop_p == 0,
        "R1 in reset", {hs_mode, ack_sup, start_p, stop_p}, 0);
    rst_ni = 1'b1;
    wq();
    chk(hs_mode == 0 && ack_sup == 0 && start_cnt == 0 && stop_cnt == 0,
        "R1 after reset", {hs_mode, ack_sup}, 0);

    // R4 R5 R8: every low-bit value of the master code
    for (int k = 0; k < 8; k++) begin
      bus_start();
      send_byte({5'b00001, 3'(k)}, 1'b1, "R4 master code recognized");
      bus_stop();
    end

    // R6: near misses
    foreach (b[i]) ;
    for (int k = 0; k < 5; k++) begin
      case (k)
        0: b = 8'h10;
        1: b = 8'h07;
        2: b = 8'h88;
        3: b = 8'h18;
        default: b = 8'hF8;
      endcase
      bus_start();
      send_byte(b, 1'b0, "R6 non-matching byte");
      bus_stop();
    end

    // R7 R9: repeated starts in high-speed mode
    bus_start();
    send_byte(8'h09, 1'b1, "R4 master code");
    bus_start();
    chk(hs_mode == 1'b1, "R7 mode held over repeated start", hs_mode, 1);
    send_byte(8'h0B, 1'b0, "R9 pattern in hs mode is traffic");
    bus_start();
    send_byte(8'h55, 1'b0, "R7 hs traffic");
    chk(hs_mode == 1'b1, "R7 mode held", hs_mode, 1);
    bus_stop();

    // R10: pattern as second byte
    bus_start();
    send_byte(8'hA0, 1'b0, "R6 first byte");
    send_byte(8'h08, 1'b0, "R10 second byte ignored");
    bus_stop();

    // R12: SDA toggles while SCL low, then a clean master code
    bus_start();
    for (int k = 0; k < 4; k++) begin
      sda = ~sda; wq();
    end
    chk(start_cnt == exp_start && stop_cnt == exp_stop, "R12 no condition while SCL low",
        start_cnt + stop_cnt, exp_start + exp_stop);
    send_byte(8'h0E, 1'b1, "R12 capture undisturbed");
    bus_stop();

    // R11: SCL rise and SDA fall in the same sample
    scl = 1'b0; wq();
    scl = 1'b1; sda = 1'b0; wq();
    chk(start_cnt == exp_start, "R11 coincident edge is not a start", start_cnt, exp_start);
    chk(hs_mode == 1'b0, "R11 mode unchanged", hs_mode, 0);
    scl = 1'b0; wq();
    bus_stop();

    // random transfers
    for (int n = 0; n < 60; n++) begin
      bus_start();
      b = ($urandom % 2) ? {5'b00001, 3'($urandom)} : 8'($urandom);
      send_byte(b, is_mc(b, exp_hs), "R4 random first byte");
      if ($urandom % 3 == 0)
        send_byte({5'b00001, 3'($urandom)}, 1'b0, "R10 random second byte");
      if ($urandom % 3 == 0) bus_stop();
      else chk(hs_mode == exp_hs, "R7 mode before repeated start", hs_mode, exp_hs);
    end
    bus_stop();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule